// File: doc/BRIEF.md
# Receive Signaling Freeze Controller

This block sits behind a receive framer. Once per multiframe it takes the signaling word the framer has gathered, robbed-bit or channel-associated, and stores it in a small circular buffer of multiframe entries. The word it presents downstream is always the one captured three multiframes earlier. Downstream logic therefore sees signaling that has settled before it is used.

Line trouble can corrupt the captured signaling. The block watches three line indications: frame sync lost, receive carrier gone, and frame alignment moved. When freezing is enabled and any of them is raised, the block stops writing to the buffer and holds its output at the last good word. Software can also force the same freeze at any time.

Once every cause has cleared, the output stays frozen for a guard period. The period is a number of 125 µs frames that depends on the framing mode. If a new cause appears before the guard period ends, the count starts again. A flag output is high whenever the output is frozen.

The controller has three states:
- RUN: the buffer accepts writes.
- FROZEN: a cause is present.
- HOLD: the guard period is running.

The transitions between them are:
- RUN→FROZEN when a cause appears.
- FROZEN→HOLD when all causes clear.
- HOLD→FROZEN when a cause returns.
- HOLD→RUN on the last guard frame.

Top module: `sigfrz_ctrl`

## Requirements
- R1: After reset, `sig_out` is all zeros and `freeze_active` is 0.
- R2: A multiframe strobe accepted in the RUN state stores `sig_in`. From the following cycle, `sig_out` shows the word accepted three strobes before it, or zero if fewer than four words have been accepted. `sig_out` changes at no other time.
- R3: While `freeze_en` is 1, a high level on `oof`, `carrier_loss` or `align_chg` sets `freeze_active` from the next cycle. A strobe in that same cycle or later, while frozen, is not stored, and `sig_out` stays unchanged.
- R4: A high level on `force_freeze` freezes the output in the same way, whatever the value of `freeze_en`.
- R5: With `freeze_en` and `force_freeze` both 0, the three line indications have no effect: `freeze_active` stays 0 and strobes are stored.
- R6: After every cause is gone, `freeze_active` stays 1 until the Nth `frame_tick` in the HOLD state, and it drops in the cycle after that tick. N depends on `mode`: 2'b00 (ESF) gives 72, 2'b01 (D4) gives 36, 2'b10 (E1) gives 48. A tick in the cycle where the causes clear does not count.
- R7: A cause arriving during HOLD returns the block to FROZEN. When that cause clears, the full N-tick count starts again from zero.
- R8: Strobes that arrive during HOLD are not stored.
- R9: `mode` value 2'b11 uses the longest guard period, 72 frames.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_tick | input | 1 | One-cycle pulse per received 125 µs frame |
| mf_strobe | input | 1 | One-cycle pulse at a multiframe boundary; `sig_in` is valid with it |
| sig_in | input | SIG_W | Signaling word captured over the multiframe that just ended |
| oof | input | 1 | Frame synchronization lost |
| carrier_loss | input | 1 | Receive carrier absent |
| align_chg | input | 1 | Frame alignment changed |
| mode | input | 2 | Framing mode: 00 ESF, 01 D4, 10 E1, 11 treated as ESF |
| freeze_en | input | 1 | Enables freezing on line indications |
| force_freeze | input | 1 | Forces a freeze |
| sig_out | output | SIG_W | Signaling word delayed by three multiframes |
| freeze_active | output | 1 | High while the output is frozen |

## Verification
The hardest situation to reach is a cause that returns partway through a guard period, followed by a check that the restarted count is full length. A count that merely resumed would release the output early.

The stimulus raises carrier loss in E1 mode and lets it clear. It then delivers 30 frame ticks and pulses an alignment change. After that it clears the change and delivers 47 ticks, which must leave the output still frozen, and then one more tick, which must release it.

Strobes are also injected in the same cycle a cause appears, and during HOLD. Both cases show through `sig_out` that nothing entered the delay line.

// File: rtl/sigfrz_pkg.sv
package sigfrz_pkg;

    typedef enum logic [1:0] {
        ST_RUN    = 2'b00,
        ST_FROZEN = 2'b01,
        ST_HOLD   = 2'b10
    } frz_state_e;

    typedef enum logic [1:0] {
        MODE_ESF  = 2'b00,
        MODE_D4   = 2'b01,
        MODE_E1   = 2'b10,
        MODE_RSVD = 2'b11
    } frame_mode_e;

endpackage

// File: rtl/sigfrz_cause.sv
// Combines line indications and the software force into one freeze request.
module sigfrz_cause (
    input  logic oof,
    input  logic carrier_loss,
    input  logic align_chg,
    input  logic freeze_en,
    input  logic force_freeze,
    output logic freeze_req
);
    logic line_fault;

    always_comb begin
        line_fault = oof | carrier_loss | align_chg;
        freeze_req = (freeze_en & line_fault) | force_freeze;
    end
endmodule

// File: rtl/sigfrz_guard_timer.sv
// Counts frame ticks during the post-recovery guard period.
module sigfrz_guard_timer
    import sigfrz_pkg::*;
#(
    parameter int ESF_FRAMES = 72,
    parameter int D4_FRAMES  = 36,
    parameter int E1_FRAMES  = 48
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clr,
    input  logic       tick,
    input  logic [1:0] mode,
    output logic       expired
);
    localparam int MAX_A  = (ESF_FRAMES > D4_FRAMES) ? ESF_FRAMES : D4_FRAMES;
    localparam int MAXF   = (MAX_A > E1_FRAMES) ? MAX_A : E1_FRAMES;
    localparam int CW     = $clog2(MAXF + 1);

    logic [CW-1:0] cnt;
    logic [CW-1:0] limit;
    logic [CW-1:0] last;
    frame_mode_e   fmode;

    always_comb begin
        fmode = frame_mode_e'(mode);
        unique case (fmode)
            MODE_ESF:  limit = CW'(ESF_FRAMES);
            MODE_D4:   limit = CW'(D4_FRAMES);
            MODE_E1:   limit = CW'(E1_FRAMES);
            MODE_RSVD: limit = CW'(MAXF);
            default:   limit = CW'(MAXF);
        endcase
        last    = limit - CW'(1);
        expired = tick & ~clr & (cnt == last);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (clr) begin
            cnt <= '0;
        end else if (tick) begin
            cnt <= cnt + CW'(1);
        end
    end
endmodule

// File: rtl/sigfrz_mf_buffer.sv
// Circular multiframe store; the read side shows the entry written DEPTH-1 writes before the newest.
module sigfrz_mf_buffer #(
    parameter int W     = 16,
    parameter int DEPTH = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [PW-1:0] ptr;
    logic [W-1:0]  mem [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ptr <= '0;
        end else if (wr_en) begin
            if (ptr == PW'(DEPTH - 1)) ptr <= '0;
            else                       ptr <= ptr + PW'(1);
        end
    end

    for (genvar i = 0; i < DEPTH; i++) begin : g_entry
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                mem[i] <= '0;
            end else if (wr_en && (ptr == PW'(i))) begin
                mem[i] <= din;
            end
        end
    end

    // After a write the pointer sits on the oldest entry.
    assign dout = mem[ptr];
endmodule

// File: rtl/sigfrz_ctrl.sv
module sigfrz_ctrl
    import sigfrz_pkg::*;
#(
    parameter int SIG_W      = 16,
    parameter int MF_DEPTH   = 4,
    parameter int ESF_FRAMES = 72,
    parameter int D4_FRAMES  = 36,
    parameter int E1_FRAMES  = 48
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             frame_tick,
    input  logic             mf_strobe,
    input  logic [SIG_W-1:0] sig_in,
    input  logic             oof,
    input  logic             carrier_loss,
    input  logic             align_chg,
    input  logic [1:0]       mode,
    input  logic             freeze_en,
    input  logic             force_freeze,
    output logic [SIG_W-1:0] sig_out,
    output logic             freeze_active
);
    frz_state_e state, nxt;
    logic       freeze_req;
    logic       expired;
    logic       tmr_clr;
    logic       buf_wr;

    sigfrz_cause u_cause (
        .oof          (oof),
        .carrier_loss (carrier_loss),
        .align_chg    (align_chg),
        .freeze_en    (freeze_en),
        .force_freeze (force_freeze),
        .freeze_req   (freeze_req)
    );

    sigfrz_guard_timer #(
        .ESF_FRAMES (ESF_FRAMES),
        .D4_FRAMES  (D4_FRAMES),
        .E1_FRAMES  (E1_FRAMES)
    ) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (tmr_clr),
        .tick    (frame_tick),
        .mode    (mode),
        .expired (expired)
    );

    sigfrz_mf_buffer #(
        .W     (SIG_W),
        .DEPTH (MF_DEPTH)
    ) u_buf (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (buf_wr),
        .din   (sig_in),
        .dout  (sig_out)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_RUN;
        else        state <= nxt;
    end

    // Next-state logic
    always_comb begin
        nxt = state;
        unique case (state)
            ST_RUN:    if (freeze_req)  nxt = ST_FROZEN;
            ST_FROZEN: if (!freeze_req) nxt = ST_HOLD;
            ST_HOLD: begin
                if (freeze_req)   nxt = ST_FROZEN;
                else if (expired) nxt = ST_RUN;
            end
            default:              nxt = ST_RUN;
        endcase
    end

    // Outputs
    always_comb begin
        freeze_active = (state != ST_RUN);
        buf_wr        = mf_strobe & (state == ST_RUN) & ~freeze_req;
        tmr_clr       = (state != ST_HOLD) | freeze_req;
    end
endmodule

// File: rtl/sigfrz_chk.sv
module sigfrz_chk #(
    parameter int SIG_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             frame_tick,
    input logic             mf_strobe,
    input logic             oof,
    input logic             carrier_loss,
    input logic             align_chg,
    input logic             freeze_en,
    input logic             force_freeze,
    input logic [SIG_W-1:0] sig_out,
    input logic             freeze_active
);
    a_r2_quiet_without_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        !mf_strobe |=> $stable(sig_out));

    a_r3_line_fault_freezes: assert property (@(posedge clk) disable iff (!rst_n)
        (freeze_en && (oof || carrier_loss || align_chg)) |=> freeze_active);

    a_r3_output_held: assert property (@(posedge clk) disable iff (!rst_n)
        freeze_active |=> $stable(sig_out));

    a_r4_force_freezes: assert property (@(posedge clk) disable iff (!rst_n)
        force_freeze |=> freeze_active);

    a_r6_release_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(freeze_active) |-> ($past(frame_tick) && !$past(force_freeze)
            && !$past(freeze_en && (oof || carrier_loss || align_chg))));
endmodule

bind sigfrz_ctrl sigfrz_chk #(.SIG_W(SIG_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .frame_tick    (frame_tick),
    .mf_strobe     (mf_strobe),
    .oof           (oof),
    .carrier_loss  (carrier_loss),
    .align_chg     (align_chg),
    .freeze_en     (freeze_en),
    .force_freeze  (force_freeze),
    .sig_out       (sig_out),
    .freeze_active (freeze_active)
);

// File: tb/tb_sigfrz_ctrl.sv
module tb_sigfrz_ctrl;
    localparam int  W        = 16;
    localparam time CLK_HALF = 5ns;

    logic         clk = 0;
    logic         rst_n = 0;
    logic         frame_tick = 0;
    logic         mf_strobe = 0;
    logic [W-1:0] sig_in = '0;
    logic         oof = 0, carrier_loss = 0, align_chg = 0;
    logic [1:0]   mode = 2'b00;
    logic         freeze_en = 0, force_freeze = 0;
    logic [W-1:0] sig_out;
    logic         freeze_active;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit finished = 0;

    typedef struct {
        logic [W-1:0] val;
        int           due;
        string        tag;
    } exp_t;

    exp_t         sb[$];
    logic [W-1:0] hist[$];

    sigfrz_ctrl dut (
        .clk(clk), .rst_n(rst_n), .frame_tick(frame_tick), .mf_strobe(mf_strobe),
        .sig_in(sig_in), .oof(oof), .carrier_loss(carrier_loss), .align_chg(align_chg),
        .mode(mode), .freeze_en(freeze_en), .force_freeze(force_freeze),
        .sig_out(sig_out), .freeze_active(freeze_active)
    );

    always #(CLK_HALF) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    // Monitor: pops expected words when due and compares
    always @(negedge clk) begin
        while (sb.size() > 0 && sb[0].due == cyc) begin
            exp_t e;
            e = sb.pop_front();
            checks++;
            if (sig_out !== e.val) begin
                errors++;
                $display("FAIL %s sig_out actual=%h expected=%h", e.tag, sig_out, e.val);
            end
        end
    end

    function automatic logic [W-1:0] model_out();
        if (hist.size() >= 4) return hist[hist.size() - 4];
        return '0;
    endfunction

    // Driver: one strobe, pushes the expected output into the scoreboard
    task automatic strobe(input logic [W-1:0] w, input bit accept, input string tag);
        exp_t e;
        mf_strobe = 1;
        sig_in    = w;
        if (accept) hist.push_back(w);
        e.val = model_out();
        e.due = cyc + 1;
        e.tag = tag;
        sb.push_back(e);
        @(negedge clk);
        mf_strobe = 0;
    endtask

    task automatic chk_flag(input logic exp, input string tag);
        checks++;
        if (freeze_active !== exp) begin
            errors++;
            $display("FAIL %s freeze_active actual=%b expected=%b", tag, freeze_active, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic ticks(input int n);
        repeat (n) begin
            frame_tick = 1;
            @(negedge clk);
            frame_tick = 0;
        end
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=timeout expected=completion");
            summary();
        end
    end

    initial begin
        idle(2);
        // R1: reset state
        checks++;
        if (sig_out !== '0) begin
            errors++;
            $display("FAIL R1 sig_out actual=%h expected=0", sig_out);
        end
        chk_flag(1'b0, "R1");
        rst_n = 1;
        idle(1);

        // R2: fill and run the three-multiframe delay
        for (int i = 0; i < 6; i++) strobe(W'(16'hA100 + i), 1, "R2");
        idle(2);

        // R5: line faults ignored with freeze disabled
        oof = 1; carrier_loss = 1; align_chg = 1;
        strobe(16'hB001, 1, "R5");
        chk_flag(1'b0, "R5");
        strobe(16'hB002, 1, "R5");
        oof = 0; carrier_loss = 0; align_chg = 0;
        idle(1);

        // R3: fault with a strobe in the same cycle, then strobe while frozen
        freeze_en = 1; mode = 2'b00;
        oof = 1;
        strobe(16'hC001, 0, "R3");
        chk_flag(1'b1, "R3");
        strobe(16'hC002, 0, "R3");
        oof = 0;
        idle(1);
        // R8: strobe in HOLD blocked
        strobe(16'hC003, 0, "R8");
        // R6: ESF guard 72 frames
        ticks(71);
        chk_flag(1'b1, "R6 ESF 71");
        ticks(1);
        chk_flag(1'b0, "R6 ESF 72");
        strobe(16'hC004, 1, "R2 after release");

        // R4: force freeze with freeze_en low, D4 guard
        freeze_en = 0; mode = 2'b01;
        force_freeze = 1;
        idle(1);
        chk_flag(1'b1, "R4");
        strobe(16'hD001, 0, "R4");
        force_freeze = 0;
        idle(1);
        ticks(35);
        chk_flag(1'b1, "R6 D4 35");
        ticks(1);
        chk_flag(1'b0, "R6 D4 36");

        // R7: restart of the guard count in E1 mode
        freeze_en = 1; mode = 2'b10;
        carrier_loss = 1;
        idle(1);
        carrier_loss = 0;
        idle(1);
        ticks(30);
        align_chg = 1;
        idle(1);
        chk_flag(1'b1, "R7 refreeze");
        align_chg = 0;
        idle(1);
        ticks(47);
        chk_flag(1'b1, "R7 E1 47 after restart");
        ticks(1);
        chk_flag(1'b0, "R7 E1 48 after restart");

        // R9: reserved mode uses 72 frames
        mode = 2'b11;
        oof = 1;
        idle(1);
        oof = 0;
        idle(1);
        ticks(71);
        chk_flag(1'b1, "R9 71");
        ticks(1);
        chk_flag(1'b0, "R9 72");
        strobe(16'hE001, 1, "R2 final");
        strobe(16'hE002, 1, "R2 final");

        idle(3);
        finished = 1;
        summary();
    end
endmodule